// File: doc/BRIEF.md
# Variable-Precision Multiply-Accumulate Slice

This block is one arithmetic slice of a larger datapath. A single control input picks how its multiplier hardware is split. In dual mode it runs two independent signed 18x19 products in the same cycle. In wide mode it runs one signed 27x27 product. Before the multiply, the slice can sum two input samples with a pre-adder, so symmetric filter taps share one multiply. It can also take one operand from a small coefficient bank inside the slice instead of from the input bus.

Each lane has its own 64-bit accumulator. A 64-bit cascade input from the neighbouring slice is added into lane 0. Lane 0's result leaves on a 64-bit cascade output, so slices can be chained without any logic between them. Every input beat passes through three register stages:

- input capture
- operand forming and multiply
- accumulate and chain

A valid flag travels with the data through the same three stages.

Top module: `vmac_slice`

## Requirements
- R1: `out_valid` rises exactly three rising clock edges after the edge that samples `in_valid` high, and stays low for beats that were not valid.
- R2: With `mode`=0 (dual), lane 0 multiplies `x_in[17:0]` by `y_in[18:0]` and lane 1 multiplies `x_in[35:18]` by `y_in[37:19]`. All four operands are two's-complement signed, and each product is sign-extended to 64 bits.
- R3: With `mode`=1 (wide), lane 0 multiplies `x_in[26:0]` by `y_in[26:0]`, both signed. `out1` is zero for that beat, and accumulator 1 keeps its value.
- R4: With `pre_en`=1, the y operand of each lane is replaced by y plus the matching field of `z_in` (same bit positions as y). The sum wraps to the operand width: 19 bits in dual mode, 27 bits in wide mode.
- R5: With `coef_en`=1, the x operand comes from the 8-entry, 27-bit coefficient bank entry chosen by the 3-bit `coef_sel`. In dual mode both lanes take that entry's low 18 bits. A bank write (`cf_we`, `cf_addr`, `cf_data`) presented in the same cycle as a beat is already visible to that beat.
- R6: With `acc_en`=1 and `acc_clr`=0, a lane's result is its previous accumulator value plus its new product (plus the cascade term on lane 0), and the accumulator takes that result. With `acc_en`=0 and `acc_clr`=0, the result excludes the old sum and the accumulator is unchanged.
- R7: With `acc_clr`=1, a lane's result excludes the old sum, and the accumulator is loaded with the new result whatever the value of `acc_en`.
- R8: `chain_in`, sampled with the beat, is added into lane 0 only, and `chain_out` always equals `out0`.
- R9: Accumulation and cascade addition wrap modulo 2^64, with no saturation.
- R10: When no valid beat reaches the output stage, `out0`, `out1` and `chain_out` hold their previous values.
- R11: After reset, `out_valid`, `out0`, `out1` and `chain_out` are zero, and both accumulators and all bank entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| mode | input | 1 | 0 = two 18x19 lanes, 1 = one 27x27 lane |
| pre_en | input | 1 | Add `z_in` fields to the y operands |
| coef_en | input | 1 | Take x operand from the coefficient bank |
| coef_sel | input | 3 | Coefficient bank entry to read |
| acc_en | input | 1 | Add to the running accumulator |
| acc_clr | input | 1 | Load accumulator with fresh result |
| x_in | input | 36 | x operands (lane 1 high, lane 0 low; wide uses bits 26:0) |
| y_in | input | 38 | y operands (lane 1 high, lane 0 low; wide uses bits 26:0) |
| z_in | input | 38 | Pre-adder second operands, same layout as `y_in` |
| chain_in | input | 64 | Cascade term from the neighbouring slice |
| cf_we | input | 1 | Coefficient bank write enable |
| cf_addr | input | 3 | Coefficient bank write address |
| cf_data | input | 27 | Coefficient bank write data |
| out_valid | output | 1 | Output beat present |
| out0 | output | 64 | Lane 0 result |
| out1 | output | 64 | Lane 1 result (zero in wide mode) |
| chain_out | output | 64 | Cascade output, copy of lane 0 result |

## Verification
The bench builds the slice with its default geometry: 18-bit and 19-bit lane operands, 27-bit wide operands, 64-bit accumulators and an 8-entry bank. That geometry brings several cases within reach:

- the most negative and most positive operand of every field, where products need every bit of a lane;
- pre-adder sums that wrap at exactly the 19-bit and 27-bit boundary;
- a cascade sum that crosses 2^63 and then returns to zero.

Directed sequences show that accumulator 1 is untouched by a wide beat and that a coefficient written in the same cycle is already used.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_WIDE = 1'b1
    } vmac_mode_e;

    localparam int LANES = 2;

endpackage

// File: rtl/vmac_coef_bank.sv
module vmac_coef_bank #(
    parameter int DEPTH = 8,
    parameter int W     = 27,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_sel,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] entry_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
        end else if (wr_en) begin
            entry_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = entry_q[rd_sel];

endmodule

// File: rtl/vmac_mul.sv
module vmac_mul #(
    parameter int AW = 27,
    parameter int BW = 27,
    parameter int PW = 64
) (
    input  logic signed [AW-1:0] a,
    input  logic signed [BW-1:0] b,
    output logic        [PW-1:0] p
);

    logic signed [AW+BW-1:0] full;

    assign full = a * b;
    assign p    = PW'(full);

endmodule

// File: rtl/vmac_acc_lane.sv
module vmac_acc_lane #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         beat,
    input  logic         lane_on,
    input  logic         acc_en,
    input  logic         acc_clr,
    input  logic [W-1:0] prod,
    input  logic [W-1:0] chain,
    output logic [W-1:0] result
);

    logic [W-1:0] acc_q;
    logic [W-1:0] base;
    logic [W-1:0] sum;

    always_comb begin
        base = (acc_en && !acc_clr) ? acc_q : '0;
        sum  = base + prod + chain;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            result <= '0;
        end else if (beat) begin
            if (lane_on) begin
                result <= sum;
                if (acc_en || acc_clr) acc_q <= sum;
            end else begin
                result <= '0;
            end
        end
    end

endmodule

// File: rtl/vmac_slice.sv
module vmac_slice
    import vmac_pkg::*;
#(
    parameter int NX         = 18,
    parameter int NY         = 19,
    parameter int NW         = 27,
    parameter int ACC_W      = 64,
    parameter int BANK_DEPTH = 8,
    localparam int SEL_W     = $clog2(BANK_DEPTH),
    localparam int XB        = 2 * NX,
    localparam int YB        = 2 * NY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode,
    input  logic             pre_en,
    input  logic             coef_en,
    input  logic [SEL_W-1:0] coef_sel,
    input  logic             acc_en,
    input  logic             acc_clr,
    input  logic [XB-1:0]    x_in,
    input  logic [YB-1:0]    y_in,
    input  logic [YB-1:0]    z_in,
    input  logic [ACC_W-1:0] chain_in,
    input  logic             cf_we,
    input  logic [SEL_W-1:0] cf_addr,
    input  logic [NW-1:0]    cf_data,
    output logic             out_valid,
    output logic [ACC_W-1:0] out0,
    output logic [ACC_W-1:0] out1,
    output logic [ACC_W-1:0] chain_out
);

    // ---------------- stage 1: input capture ----------------
    logic             v_s1, pre_s1, cf_s1, acc_s1, clr_s1;
    vmac_mode_e       mode_s1;
    logic [SEL_W-1:0] sel_s1;
    logic [XB-1:0]    x_s1;
    logic [YB-1:0]    y_s1, z_s1;
    logic [ACC_W-1:0] ch_s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_s1    <= 1'b0;
            mode_s1 <= MODE_DUAL;
            pre_s1  <= 1'b0;
            cf_s1   <= 1'b0;
            sel_s1  <= '0;
            acc_s1  <= 1'b0;
            clr_s1  <= 1'b0;
            x_s1    <= '0;
            y_s1    <= '0;
            z_s1    <= '0;
            ch_s1   <= '0;
        end else begin
            v_s1    <= in_valid;
            mode_s1 <= vmac_mode_e'(mode);
            pre_s1  <= pre_en;
            cf_s1   <= coef_en;
            sel_s1  <= coef_sel;
            acc_s1  <= acc_en;
            clr_s1  <= acc_clr;
            x_s1    <= x_in;
            y_s1    <= y_in;
            z_s1    <= z_in;
            ch_s1   <= chain_in;
        end
    end

    // ---------------- coefficient bank ----------------
    logic [NW-1:0] coef;

    vmac_coef_bank #(.DEPTH(BANK_DEPTH), .W(NW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cf_we),
        .wr_addr (cf_addr),
        .wr_data (cf_data),
        .rd_sel  (sel_s1),
        .rd_data (coef)
    );

    // ---------------- operand forming ----------------
    logic signed [NW-1:0] xw, yw, m0_a, m0_b;
    logic signed [NX-1:0] xd0, xd1;
    logic signed [NY-1:0] yd0, yd1;

    always_comb begin
        xw  = cf_s1 ? coef : x_s1[NW-1:0];
        yw  = y_s1[NW-1:0] + (pre_s1 ? z_s1[NW-1:0] : '0);
        xd0 = cf_s1 ? coef[NX-1:0] : x_s1[NX-1:0];
        xd1 = cf_s1 ? coef[NX-1:0] : x_s1[XB-1:NX];
        yd0 = y_s1[NY-1:0]  + (pre_s1 ? z_s1[NY-1:0]  : '0);
        yd1 = y_s1[YB-1:NY] + (pre_s1 ? z_s1[YB-1:NY] : '0);
        unique case (mode_s1)
            MODE_WIDE: begin
                m0_a = xw;
                m0_b = yw;
            end
            MODE_DUAL: begin
                m0_a = NW'(xd0);
                m0_b = NW'(yd0);
            end
        endcase
    end

    // lane 0 multiplier is wide enough for both modes; lane 1 is lane-sized
    logic [LANES-1:0][ACC_W-1:0] prod_c;

    vmac_mul #(.AW(NW), .BW(NW), .PW(ACC_W)) u_mul0 (
        .a (m0_a),
        .b (m0_b),
        .p (prod_c[0])
    );

    vmac_mul #(.AW(NX), .BW(NY), .PW(ACC_W)) u_mul1 (
        .a (xd1),
        .b (yd1),
        .p (prod_c[1])
    );

    // ---------------- stage 2: product register ----------------
    logic                        v_s2, acc_s2, clr_s2;
    vmac_mode_e                  mode_s2;
    logic [ACC_W-1:0]            ch_s2;
    logic [LANES-1:0][ACC_W-1:0] prod_s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_s2    <= 1'b0;
            mode_s2 <= MODE_DUAL;
            acc_s2  <= 1'b0;
            clr_s2  <= 1'b0;
            ch_s2   <= '0;
            prod_s2 <= '0;
        end else begin
            v_s2    <= v_s1;
            mode_s2 <= mode_s1;
            acc_s2  <= acc_s1;
            clr_s2  <= clr_s1;
            ch_s2   <= ch_s1;
            prod_s2 <= prod_c;
        end
    end

    // ---------------- stage 3: accumulate and chain ----------------
    logic [LANES-1:0]            lane_on;
    logic [LANES-1:0][ACC_W-1:0] lane_res;

    always_comb begin
        unique case (mode_s2)
            MODE_DUAL: lane_on = '1;
            MODE_WIDE: lane_on = LANES'(1);
        endcase
    end

    for (genvar L = 0; L < LANES; L++) begin : g_lane
        vmac_acc_lane #(.W(ACC_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .beat    (v_s2),
            .lane_on (lane_on[L]),
            .acc_en  (acc_s2),
            .acc_clr (clr_s2),
            .prod    (prod_s2[L]),
            .chain   ((L == 0) ? ch_s2 : '0),
            .result  (lane_res[L])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= v_s2;
    end

    assign out0      = lane_res[0];
    assign out1      = lane_res[1];
    assign chain_out = lane_res[0];

endmodule

// File: rtl/vmac_slice_chk.sv
module vmac_slice_chk #(
    parameter int NY    = 19,
    parameter int ACC_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode,
    input logic             pre_en,
    input logic             acc_en,
    input logic             acc_clr,
    input logic [2*NY-1:0]  y_in,
    input logic [ACC_W-1:0] chain_in,
    input logic             out_valid,
    input logic [ACC_W-1:0] out0,
    input logic [ACC_W-1:0] out1
);

    logic [1:0] edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               edges_q <= '0;
        else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3
    wide_lane1_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |-> ##3 (out1 == '0));

    // R2
    dual_zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode && !pre_en && !acc_en && !acc_clr && (y_in[2*NY-1:NY] == '0))
        |-> ##3 (out1 == '0));

    // R7
    clear_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode && acc_clr && !pre_en && (y_in[NY-1:0] == '0) && (chain_in == '0))
        |-> ##3 (out0 == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out0) && $stable(out1)));

endmodule

bind vmac_slice vmac_slice_chk #(.NY(NY), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .pre_en    (pre_en),
    .acc_en    (acc_en),
    .acc_clr   (acc_clr),
    .y_in      (y_in),
    .chain_in  (chain_in),
    .out_valid (out_valid),
    .out0      (out0),
    .out1      (out1)
);

// File: tb/tb_vmac_slice.sv
`timescale 1ns/1ps
module tb_vmac_slice;

    localparam int NX = 18, NY = 19, NW = 27, ACC_W = 64, BANK_DEPTH = 8;
    localparam int XB = 2 * NX, YB = 2 * NY;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, mode = 1'b0, pre_en = 1'b0, coef_en = 1'b0;
    logic [2:0]       coef_sel = '0;
    logic             acc_en = 1'b0, acc_clr = 1'b0;
    logic [XB-1:0]    x_in = '0;
    logic [YB-1:0]    y_in = '0, z_in = '0;
    logic [ACC_W-1:0] chain_in = '0;
    logic             cf_we = 1'b0;
    logic [2:0]       cf_addr = '0;
    logic [NW-1:0]    cf_data = '0;
    logic             out_valid;
    logic [ACC_W-1:0] out0, out1, chain_out;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    vmac_slice #(.NX(NX), .NY(NY), .NW(NW), .ACC_W(ACC_W), .BANK_DEPTH(BANK_DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .pre_en(pre_en),
        .coef_en(coef_en), .coef_sel(coef_sel), .acc_en(acc_en), .acc_clr(acc_clr),
        .x_in(x_in), .y_in(y_in), .z_in(z_in), .chain_in(chain_in),
        .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
        .out_valid(out_valid), .out0(out0), .out1(out1), .chain_out(chain_out)
    );

    typedef struct packed {
        logic        md;
        logic        pre;
        logic        cf;
        logic [2:0]  sel;
        logic        acc;
        logic        clr;
        longint      x0, x1, y0, y1, z0, z1;
        logic [63:0] ch;
        logic [63:0] e0, e1;
    } vec_t;

    localparam int NVEC = 16;
    // Accumulators run across entries 7..15 in order; bank[2]=100, bank[5]=-3 preloaded.
    localparam vec_t TBL [NVEC] = '{
        '{1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 64'sd3, -64'sd5, 64'sd4, 64'sd6, 64'sd0, 64'sd0,
          64'd0, 64'sd12, -64'sd30},
        '{1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, -64'sd131072, 64'sd131071, -64'sd262144, 64'sd262143, 64'sd0, 64'sd0,
          64'd0, 64'sd34359738368, 64'sd34359345153},
        '{1'b1,1'b0,1'b0,3'd0,1'b0,1'b0, -64'sd67108864, 64'sd0, 64'sd67108863, 64'sd0, 64'sd0, 64'sd0,
          64'd0, -64'sd4503599560261632, 64'sd0},
        '{1'b0,1'b1,1'b0,3'd0,1'b0,1'b0, 64'sd7, 64'sd2, 64'sd10, 64'sd262143, -64'sd3, 64'sd1,
          64'd0, 64'sd49, -64'sd524288},
        '{1'b1,1'b1,1'b0,3'd0,1'b0,1'b0, 64'sd3, 64'sd0, 64'sd67108863, 64'sd0, 64'sd1, 64'sd0,
          64'd0, -64'sd201326592, 64'sd0},
        '{1'b0,1'b0,1'b1,3'd2,1'b0,1'b0, 64'sd999, 64'sd999, 64'sd3, -64'sd2, 64'sd0, 64'sd0,
          64'd0, 64'sd300, -64'sd200},
        '{1'b1,1'b0,1'b1,3'd5,1'b0,1'b0, 64'sd999, 64'sd0, 64'sd1000, 64'sd0, 64'sd0, 64'sd0,
          64'd0, -64'sd3000, 64'sd0},
        '{1'b0,1'b0,1'b0,3'd0,1'b1,1'b1, 64'sd2, 64'sd3, 64'sd5, 64'sd3, 64'sd0, 64'sd0,
          64'd0, 64'sd10, 64'sd9},
        '{1'b0,1'b0,1'b0,3'd0,1'b1,1'b0, 64'sd1, -64'sd1, 64'sd4, 64'sd20, 64'sd0, 64'sd0,
          64'd0, 64'sd14, -64'sd11},
        '{1'b0,1'b0,1'b0,3'd0,1'b1,1'b0, 64'sd1, 64'sd0, 64'sd1, 64'sd0, 64'sd0, 64'sd0,
          64'd1000, 64'sd1015, -64'sd11},
        '{1'b1,1'b0,1'b0,3'd0,1'b1,1'b0, 64'sd2, 64'sd0, 64'sd2, 64'sd0, 64'sd0, 64'sd0,
          64'd0, 64'sd1019, 64'sd0},
        '{1'b0,1'b0,1'b0,3'd0,1'b1,1'b0, 64'sd0, 64'sd1, 64'sd0, 64'sd1, 64'sd0, 64'sd0,
          64'd0, 64'sd1019, -64'sd10},
        '{1'b0,1'b0,1'b0,3'd0,1'b0,1'b0, 64'sd2, 64'sd1, 64'sd3, 64'sd1, 64'sd0, 64'sd0,
          64'hFFFF_FFFF_FFFF_FFFB, 64'sd1, 64'sd1},
        '{1'b0,1'b0,1'b0,3'd0,1'b1,1'b0, 64'sd1, 64'sd0, 64'sd1, 64'sd0, 64'sd0, 64'sd0,
          64'd0, 64'sd1020, -64'sd10},
        '{1'b0,1'b0,1'b0,3'd0,1'b0,1'b1, 64'sd1, 64'sd0, 64'sd1, 64'sd0, 64'sd0, 64'sd0,
          64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'd0},
        '{1'b0,1'b0,1'b0,3'd0,1'b1,1'b0, 64'sd0, 64'sd0, 64'sd0, 64'sd0, 64'sd0, 64'sd0,
          64'h8000_0000_0000_0000, 64'd0, 64'd0}
    };

    function automatic string req_of(input int i);
        case (i)
            0, 1:      return "R2";
            2, 10, 11: return "R3";
            3, 4:      return "R4";
            5, 6:      return "R5";
            7, 14:     return "R7";
            8, 13:     return "R6";
            9, 12:     return "R8";
            default:   return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        mode     = v.md;
        pre_en   = v.pre;
        coef_en  = v.cf;
        coef_sel = v.sel;
        acc_en   = v.acc;
        acc_clr  = v.clr;
        chain_in = v.ch;
        if (v.md) begin
            x_in = XB'(v.x0[NW-1:0]);
            y_in = YB'(v.y0[NW-1:0]);
            z_in = YB'(v.z0[NW-1:0]);
        end else begin
            x_in = {v.x1[NX-1:0], v.x0[NX-1:0]};
            y_in = {v.y1[NY-1:0], v.y0[NY-1:0]};
            z_in = {v.z1[NY-1:0], v.z0[NY-1:0]};
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", {63'd0, out_valid}, 64'd0);
        chk("R11", out0, 64'd0);
        chk("R11", out1, 64'd0);
        chk("R11", chain_out, 64'd0);
        rst_n = 1'b1;

        // preload coefficient bank
        @(negedge clk);
        cf_we = 1'b1; cf_addr = 3'd2; cf_data = 27'd100;
        @(negedge clk);
        cf_addr = 3'd5; cf_data = 27'h7FF_FFFD;
        @(negedge clk);
        cf_we = 1'b0;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(req_of(i), out0, TBL[i].e0);
            chk(req_of(i), out1, TBL[i].e1);
            chk("R8", chain_out, TBL[i].e0);
            chk("R1", {63'd0, out_valid}, 64'd1);
        end

        // R5: same-cycle bank write is seen; R1: exact latency
        @(negedge clk);
        drive('{1'b0,1'b0,1'b1,3'd1,1'b0,1'b0, 64'sd77, 64'sd77, 64'sd2, 64'sd3, 64'sd0, 64'sd0,
                64'd0, 64'd0, 64'd0});
        cf_we = 1'b1; cf_addr = 3'd1; cf_data = 27'd9;
        in_valid = 1'b1;
        @(negedge clk);
        cf_we = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk("R1", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        chk("R1", {63'd0, out_valid}, 64'd1);
        chk("R5", out0, 64'd18);
        chk("R5", out1, 64'd27);

        // R10: idle cycles with changing inputs leave outputs alone
        @(negedge clk);
        mode = 1'b1; x_in = '1; y_in = '1; chain_in = 64'd55; acc_clr = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", {63'd0, out_valid}, 64'd0);
        chk("R10", out0, 64'd18);
        chk("R10", out1, 64'd27);
        chk("R10", chain_out, 64'd18);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule